// File: doc/BRIEF.md
# Host Bus Snoop Cycle Generator

This block keeps the processor caches coherent while PCI masters read and write system memory. Every inbound PCI memory access toward system memory, and every beat of a burst, is handed to the generator as a single request carrying the direction and the already translated host address. The generator then starts one address-only snoop transaction on the host CPU bus. It drives fixed transfer attributes: a single beat, a four-byte size, and a transfer type chosen by direction. After the host acknowledges the address, it watches the address-retry line for a fixed number of clocks.

When no cache objects, the generator emits a one-cycle proceed strobe and the PCI target logic completes the access. When a processor cache or a write-back L2 cache pulls address-retry low inside the window, this is a snoop hit. The generator raises a retry request so that the PCI target can terminate the master with a target retry. It then stays busy until the PCI side has acknowledged the retry and the cache has reported that its writeback is complete. Host addresses with the most significant bit set belong to the upper, non-cacheable half. The snoop still runs for them, but the result is always an abort strobe that cancels the memory cycle.

Only one snoop is in flight at a time. Requests that arrive while the generator is not ready are dropped, and the PCI side holds its access until the ready output returns.

Top module: `host_snoop_gen`

## Requirements
- R1: While reset is high and in the cycle after it, acc_ready is 1, host_ts_n is 1, host_tbst_n is 1, host_tsize, host_tt and host_addr are 0, and snoop_proceed, snoop_retry_req and snoop_abort are 0.
- R2: A request sampled while acc_ready is 1 drives host_ts_n low for exactly the next cycle. From that cycle until the address acknowledge is sampled, host_addr equals the captured request address. Outside that span host_addr is 0.
- R3: host_tbst_n is 1 in every cycle, so each snoop is a single-beat transfer.
- R4: From the cycle with host_ts_n low until the address acknowledge is sampled, host_tsize is 3'b100 (four bytes). In all other cycles it is 0.
- R5: In the same span, host_tt is 4'b0101 for a read (acc_write=0) and 4'b0001 for a write (acc_write=1). In all other cycles it is 0.
- R6: host_artry_n is sampled only on the ARTRY_WIN clock edges that follow the edge at which host_aack is sampled high. A low value at any other time has no effect. The outcome strobe appears in the cycle after the last edge of the window.
- R7: If the address MSB is 0 and host_artry_n stays 1 through the whole window, snoop_proceed is high for exactly one cycle.
- R8: If the address MSB is 0 and host_artry_n is low on any window edge, snoop_retry_req rises instead of snoop_proceed. It stays high until retry_ack is sampled and falls in the cycle after.
- R9: If the address MSB is 1, snoop_abort is high for exactly one cycle and neither snoop_proceed nor snoop_retry_req rises, whatever host_artry_n does.
- R10: acc_ready is 0 from the cycle after a request is accepted until the outcome cycle. Requests presented while acc_ready is 0 start no snoop.
- R11: After a hit, acc_ready returns to 1 only in the cycle after both retry_ack and wb_done have been sampled high, in either order or together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | PCI access (or burst beat) needs a snoop |
| acc_write | input | 1 | Direction of the access, 1 = write |
| acc_addr | input | AW | Translated host address of the access |
| acc_ready | output | 1 | Generator can accept a request |
| host_aack | input | 1 | Host address acknowledge |
| host_artry_n | input | 1 | Host address retry, active low (snoop hit) |
| retry_ack | input | 1 | PCI target has issued the requested retry |
| wb_done | input | 1 | Cache writeback after a hit is finished |
| host_ts_n | output | 1 | Transfer start, active low |
| host_tbst_n | output | 1 | Burst indicator, active low, held negated |
| host_tsize | output | 3 | Transfer size |
| host_tt | output | 4 | Transfer type |
| host_addr | output | AW | Snoop address |
| snoop_proceed | output | 1 | One-cycle strobe: access may complete |
| snoop_retry_req | output | 1 | Request a PCI target retry (held until retry_ack) |
| snoop_abort | output | 1 | One-cycle strobe: non-cacheable address, cancel the access |

## Verification
The hardest case to reach is a retry low level that falls on exactly one edge of the sampling window, with another low level just outside the window that must be ignored. The stimulus sweeps every retry pattern across the window. It combines each pattern with several address-acknowledge delays, and it holds retry low during the wait for the acknowledge and on the acknowledge edge itself. A second difficult case is the release after a hit. The stimulus alternates the order of the retry acknowledge and the writeback completion. It also presents stray requests while the block is busy, so the ready output and the start strobe show that those requests were dropped.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_AACK,
        ST_WIN,
        ST_RETRY
    } snp_state_t;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_GO,
        OUT_RETRY,
        OUT_ABORT
    } snp_outcome_t;

    typedef struct packed {
        logic       ts_n;
        logic       tbst_n;
        logic [2:0] tsize;
        logic [3:0] tt;
    } host_ctl_t;

    localparam logic [2:0] TSIZE_WORD = 3'b100;
    localparam logic [3:0] TT_SNOOP_RD = 4'b0101;
    localparam logic [3:0] TT_SNOOP_WR = 4'b0001;

    function automatic logic [3:0] snoop_tt(input logic wr);
        return wr ? TT_SNOOP_WR : TT_SNOOP_RD;
    endfunction

    function automatic snp_outcome_t resolve(input logic noncache, input logic hit);
        if (noncache) return OUT_ABORT;
        if (hit)      return OUT_RETRY;
        return OUT_GO;
    endfunction

endpackage

// File: rtl/snp_window.sv
module snp_window #(
    parameter int WIN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic artry_n,
    output logic done,
    output logic hit
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic          hit_q;

    assign done = active && (cnt == LAST);
    assign hit  = hit_q | (active & ~artry_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            hit_q  <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            hit_q  <= 1'b0;
        end else if (active) begin
            hit_q <= hit;
            cnt   <= cnt + 1'b1;
            if (done) active <= 1'b0;
        end
    end
endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl
    import snp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_req,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic          host_aack,
    input  logic          win_done,
    input  logic          win_hit,
    input  logic          retry_ack,
    input  logic          wb_done,
    output snp_state_t    state,
    output logic          win_start,
    output logic          cur_write,
    output logic [AW-1:0] cur_addr,
    output logic          proceed,
    output logic          abort,
    output logic          retry_req,
    output logic          ready
);
    logic ack_seen, wb_seen, ack_now, wb_now;

    assign win_start = (state == ST_AACK) && host_aack;
    assign ack_now   = ack_seen | retry_ack;
    assign wb_now    = wb_seen | wb_done;
    assign retry_req = (state == ST_RETRY) && !ack_seen;
    assign ready     = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_write <= 1'b0;
            cur_addr  <= '0;
            proceed   <= 1'b0;
            abort     <= 1'b0;
            ack_seen  <= 1'b0;
            wb_seen   <= 1'b0;
        end else begin
            proceed <= 1'b0;
            abort   <= 1'b0;
            unique case (state)
                ST_IDLE: if (acc_req) begin
                    cur_write <= acc_write;
                    cur_addr  <= acc_addr;
                    state     <= ST_START;
                end
                ST_START: state <= ST_AACK;
                ST_AACK:  if (host_aack) state <= ST_WIN;
                ST_WIN: if (win_done) begin
                    unique case (resolve(cur_addr[AW-1], win_hit))
                        OUT_ABORT: begin abort   <= 1'b1; state <= ST_IDLE; end
                        OUT_RETRY: begin
                            ack_seen <= 1'b0;
                            wb_seen  <= 1'b0;
                            state    <= ST_RETRY;
                        end
                        default:   begin proceed <= 1'b1; state <= ST_IDLE; end
                    endcase
                end
                ST_RETRY: begin
                    ack_seen <= ack_now;
                    wb_seen  <= wb_now;
                    if (ack_now && wb_now) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/snp_attr.sv
module snp_attr
    import snp_pkg::*;
#(
    parameter int AW = 32
) (
    input  snp_state_t    state,
    input  logic          cur_write,
    input  logic [AW-1:0] cur_addr,
    output host_ctl_t     ctl,
    output logic [AW-1:0] addr
);
    logic in_addr_phase;

    assign in_addr_phase = (state == ST_START) || (state == ST_AACK);

    always_comb begin
        ctl.ts_n   = (state != ST_START);
        ctl.tbst_n = 1'b1;
        ctl.tsize  = in_addr_phase ? TSIZE_WORD : 3'b000;
        ctl.tt     = in_addr_phase ? snoop_tt(cur_write) : 4'b0000;
        addr       = in_addr_phase ? cur_addr : '0;
    end
endmodule

// File: rtl/host_snoop_gen.sv
module host_snoop_gen
    import snp_pkg::*;
#(
    parameter int AW        = 32,
    parameter int ARTRY_WIN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_req,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    output logic          acc_ready,
    input  logic          host_aack,
    input  logic          host_artry_n,
    input  logic          retry_ack,
    input  logic          wb_done,
    output logic          host_ts_n,
    output logic          host_tbst_n,
    output logic [2:0]    host_tsize,
    output logic [3:0]    host_tt,
    output logic [AW-1:0] host_addr,
    output logic          snoop_proceed,
    output logic          snoop_retry_req,
    output logic          snoop_abort
);
    snp_state_t    state;
    logic          win_start, win_done, win_hit, cur_write;
    logic [AW-1:0] cur_addr;
    host_ctl_t     ctl;

    snp_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst),
        .acc_req(acc_req), .acc_write(acc_write), .acc_addr(acc_addr),
        .host_aack(host_aack), .win_done(win_done), .win_hit(win_hit),
        .retry_ack(retry_ack), .wb_done(wb_done),
        .state(state), .win_start(win_start),
        .cur_write(cur_write), .cur_addr(cur_addr),
        .proceed(snoop_proceed), .abort(snoop_abort),
        .retry_req(snoop_retry_req), .ready(acc_ready)
    );

    snp_window #(.WIN(ARTRY_WIN)) u_win (
        .clk(clk), .rst(rst), .start(win_start), .artry_n(host_artry_n),
        .done(win_done), .hit(win_hit)
    );

    snp_attr #(.AW(AW)) u_attr (
        .state(state), .cur_write(cur_write), .cur_addr(cur_addr),
        .ctl(ctl), .addr(host_addr)
    );

    assign host_ts_n   = ctl.ts_n;
    assign host_tbst_n = ctl.tbst_n;
    assign host_tsize  = ctl.tsize;
    assign host_tt     = ctl.tt;
endmodule

// File: rtl/snp_checker.sv
module snp_checker (
    input logic       clk,
    input logic       rst,
    input logic       acc_req,
    input logic       acc_ready,
    input logic       host_artry_n,
    input logic       retry_ack,
    input logic       host_ts_n,
    input logic [2:0] host_tsize,
    input logic [3:0] host_tt,
    input logic       snoop_proceed,
    input logic       snoop_retry_req,
    input logic       snoop_abort
);
    a_r2_ts_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !host_ts_n |=> host_ts_n);

    a_r2_ts_after_accept: assert property (@(posedge clk) disable iff (rst)
        $fell(host_ts_n) |-> $past(acc_ready && acc_req));

    a_r4_size_word: assert property (@(posedge clk) disable iff (rst)
        !host_ts_n |-> host_tsize == 3'b100);

    a_r5_tt_code: assert property (@(posedge clk) disable iff (rst)
        !host_ts_n |-> (host_tt == 4'b0101 || host_tt == 4'b0001));

    a_r7_no_hit_last_edge: assert property (@(posedge clk) disable iff (rst)
        snoop_proceed |-> $past(host_artry_n));

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({snoop_proceed, snoop_abort, snoop_retry_req}));

    a_r10_busy_before_outcome: assert property (@(posedge clk) disable iff (rst)
        (snoop_proceed || snoop_abort) |-> $past(!acc_ready));

    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (snoop_retry_req && !retry_ack) |=> !acc_ready);
endmodule

bind host_snoop_gen snp_checker i_snp_checker (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_ready(acc_ready),
    .host_artry_n(host_artry_n), .retry_ack(retry_ack),
    .host_ts_n(host_ts_n), .host_tsize(host_tsize), .host_tt(host_tt),
    .snoop_proceed(snoop_proceed), .snoop_retry_req(snoop_retry_req),
    .snoop_abort(snoop_abort)
);

// File: tb/test_host_snoop_gen.sv
`timescale 1ns/1ps
module test_host_snoop_gen;
    localparam int AW  = 32;
    localparam int WIN = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_req, acc_write, host_aack, host_artry_n, retry_ack, wb_done;
    logic [AW-1:0] acc_addr;
    logic          acc_ready, host_ts_n, host_tbst_n;
    logic [2:0]    host_tsize;
    logic [3:0]    host_tt;
    logic [AW-1:0] host_addr;
    logic          snoop_proceed, snoop_retry_req, snoop_abort;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    host_snoop_gen #(.AW(AW), .ARTRY_WIN(WIN)) i_host_snoop_gen (
        .clk(clk), .rst(rst),
        .acc_req(acc_req), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_ready(acc_ready), .host_aack(host_aack), .host_artry_n(host_artry_n),
        .retry_ack(retry_ack), .wb_done(wb_done),
        .host_ts_n(host_ts_n), .host_tbst_n(host_tbst_n), .host_tsize(host_tsize),
        .host_tt(host_tt), .host_addr(host_addr),
        .snoop_proceed(snoop_proceed), .snoop_retry_req(snoop_retry_req),
        .snoop_abort(snoop_abort)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_outputs(input string tag);
        check({tag, " ts_n idle"}, 64'(host_ts_n), 64'd1);
        check({tag, " R3 tbst_n"}, 64'(host_tbst_n), 64'd1);
        check({tag, " R4 tsize idle"}, 64'(host_tsize), 64'd0);
        check({tag, " R5 tt idle"}, 64'(host_tt), 64'd0);
        check({tag, " R2 addr idle"}, 64'(host_addr), 64'd0);
    endtask

    task automatic run_snoop(input logic wr, input logic msb, input int dly,
                             input int pat, input logic [AW-1:0] addr);
        logic [3:0] tt_exp;
        logic       hit_exp;
        logic       ack_first;
        tt_exp    = wr ? 4'b0001 : 4'b0101;
        hit_exp   = (pat != 0) && !msb;
        ack_first = pat[0] ^ wr;

        acc_req = 1'b1; acc_write = wr; acc_addr = addr;
        @(posedge clk);
        @(negedge clk);
        acc_req = 1'b0;
        check("R2 ts_n low", 64'(host_ts_n), 64'd0);
        check("R2 addr", 64'(host_addr), 64'(addr));
        check("R3 tbst_n", 64'(host_tbst_n), 64'd1);
        check("R4 tsize", 64'(host_tsize), 64'd4);
        check("R5 tt", 64'(host_tt), 64'(tt_exp));
        check("R10 busy", 64'(acc_ready), 64'd0);
        @(posedge clk);
        for (int j = 0; j < dly; j++) begin
            @(negedge clk);
            check("R2 ts_n single", 64'(host_ts_n), 64'd1);
            check("R5 tt held", 64'(host_tt), 64'(tt_exp));
            host_artry_n = (dly == 2) ? 1'b0 : 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        check("R2 addr held", 64'(host_addr), 64'(addr));
        check("R4 tsize held", 64'(host_tsize), 64'd4);
        host_aack = 1'b1;
        host_artry_n = (dly >= 1) ? 1'b0 : 1'b1;
        @(posedge clk);
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            host_aack = 1'b0;
            host_artry_n = !pat[i];
            acc_req = (i == 0);
            acc_addr = ~addr;
            check("R6 no early outcome",
                  64'({snoop_proceed, snoop_retry_req, snoop_abort}), 64'd0);
            check("R10 busy in window", 64'(acc_ready), 64'd0);
            check("R10 no new ts", 64'(host_ts_n), 64'd1);
            @(posedge clk);
        end
        @(negedge clk);
        acc_req = 1'b0;
        host_artry_n = 1'b1;
        check("R7 proceed", 64'(snoop_proceed), 64'(!msb && pat == 0));
        check("R8 retry_req", 64'(snoop_retry_req), 64'(hit_exp));
        check("R9 abort", 64'(snoop_abort), 64'(msb));
        check("R10 ready at outcome", 64'(acc_ready), 64'(!hit_exp));
        check("R10 stray req ignored", 64'(host_ts_n), 64'd1);
        check("R6 window tt off", 64'(host_tt), 64'd0);
        if (hit_exp) begin
            acc_req = 1'b1;
            @(posedge clk);
            @(negedge clk);
            acc_req = 1'b0;
            check("R10 req ignored in retry", 64'(host_ts_n), 64'd1);
            check("R8 retry held", 64'(snoop_retry_req), 64'd1);
            check("R8 no proceed", 64'(snoop_proceed), 64'd0);
            if (ack_first) begin
                retry_ack = 1'b1;
                @(posedge clk);
                @(negedge clk);
                retry_ack = 1'b0;
                check("R8 retry drops", 64'(snoop_retry_req), 64'd0);
                check("R11 wait wb", 64'(acc_ready), 64'd0);
                wb_done = 1'b1;
                @(posedge clk);
                @(negedge clk);
                wb_done = 1'b0;
                check("R11 released", 64'(acc_ready), 64'd1);
            end else begin
                wb_done = 1'b1;
                @(posedge clk);
                @(negedge clk);
                wb_done = 1'b0;
                check("R8 retry until ack", 64'(snoop_retry_req), 64'd1);
                check("R11 wait ack", 64'(acc_ready), 64'd0);
                retry_ack = 1'b1;
                @(posedge clk);
                @(negedge clk);
                retry_ack = 1'b0;
                check("R8 retry drops", 64'(snoop_retry_req), 64'd0);
                check("R11 released", 64'(acc_ready), 64'd1);
            end
        end else begin
            @(posedge clk);
            @(negedge clk);
            check("R7 single pulse", 64'(snoop_proceed), 64'd0);
            check("R9 single pulse", 64'(snoop_abort), 64'd0);
            check("R10 ready", 64'(acc_ready), 64'd1);
            idle_outputs("after");
        end
    endtask

    initial begin
        rst = 1'b1; acc_req = 1'b0; acc_write = 1'b0; acc_addr = '0;
        host_aack = 1'b0; host_artry_n = 1'b1; retry_ack = 1'b0; wb_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready", 64'(acc_ready), 64'd1);
        check("R1 strobes", 64'({snoop_proceed, snoop_retry_req, snoop_abort}), 64'd0);
        idle_outputs("R1");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 ready after", 64'(acc_ready), 64'd1);
        idle_outputs("R1 after");
        for (int wr = 0; wr < 2; wr++)
            for (int msb = 0; msb < 2; msb++)
                for (int d = 0; d < 3; d++)
                    for (int p = 0; p < (1 << WIN); p++)
                        run_snoop(wr[0], msb[0], d, p,
                                  {msb[0], 31'(32'h0123_4560 + 32'(p * 4 + d * 64 + wr * 512))});
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule